// File: doc/BRIEF.md
# Pulse-Coded Isolation Link Channel

This block models one channel of a digital isolation link in clock-cycle terms. A transmit encoder watches a single-bit input. It sends a one-cycle "set" strobe when the input rises and a one-cycle "clear" strobe when it falls. A receive decoder keeps a bistable output that these strobes drive high or low. Edge-only signalling would lose the level if a strobe went missing. To keep the level correct at DC, the encoder re-sends a strobe that matches the present input level whenever no strobe has gone out for `REFRESH_CYCLES` cycles.

The receive decoder runs a watchdog. If no strobe of either kind arrives for `WDOG_CYCLES` cycles, it treats the far side as dead. It then raises a fault flag and forces the output to the safe level `DEFAULT_OUT`. The two halves meet only through the two-wire strobe link. The top module brings that link out to its ports: the encoder's strobes leave on `tx_set_o`/`tx_clr_o`, and the decoder takes its strobes from `rx_set_i`/`rx_clr_i`. The integrator normally ties each output to the matching input, and may insert a barrier model or a fault injector between them.

Encoder states: `TX_HOLD` (no strobe this cycle), `TX_EDGE` (strobe for an input transition) and `TX_REFRESH` (idle refresh strobe). The next state is `TX_EDGE` on a detected transition. Otherwise it is `TX_REFRESH` when the idle count reaches its limit, and `TX_HOLD` in every other case. Decoder states: `RX_TRACK` (strobes arriving) and `RX_FAULT` (watchdog expired). The decoder moves from `RX_TRACK` to `RX_FAULT` when the watchdog expires with no strobe, and from `RX_FAULT` back to `RX_TRACK` on any strobe.

Top module: `iso_pulse_link`

## Requirements
- R1: When `data_in` rises and is sampled high at clock edge k, after being low at edge k-1, `tx_set_o` is high for exactly the cycle that follows edge k+2, after a synchronizer of two flops.
- R2: When `data_in` falls and is sampled low at edge k, `tx_clr_o` is high for exactly the cycle that follows edge k+2.
- R3: `tx_set_o` and `tx_clr_o` are never high together, and neither stays high for two cycles in a row.
- R4: While no transition occurs, the encoder emits a refresh strobe exactly `REFRESH_CYCLES` cycles after the previous strobe of either kind. The strobe is `tx_set_o` if the synchronized level is 1 and `tx_clr_o` if it is 0.
- R5: A cycle with only `rx_set_i` high makes `data_out` 1 after the next edge. A cycle with only `rx_clr_i` high makes it 0. With neither high, and the watchdog not expiring, `data_out` holds.
- R6: A cycle with `rx_set_i` and `rx_clr_i` both high is a protocol error, and `data_out` keeps its value.
- R7: If no strobe is received at `WDOG_CYCLES` consecutive edges, `fault_o` goes to 1 at that edge, and `data_out` equals `DEFAULT_OUT` for as long as `fault_o` is 1.
- R8: Any received strobe, including a colliding pair, clears `fault_o` at the next edge, and a single strobe also sets `data_out` as in R5.
- R9: After reset, `data_out` equals `DEFAULT_OUT`, `fault_o` is 0, and both transmit strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_in | input | 1 | Asynchronous level to carry across the link |
| tx_set_o | output | 1 | Encoder set strobe (drive level high) |
| tx_clr_o | output | 1 | Encoder clear strobe (drive level low) |
| rx_set_i | input | 1 | Set strobe arriving at the decoder |
| rx_clr_i | input | 1 | Clear strobe arriving at the decoder |
| data_out | output | 1 | Decoded bistable level |
| fault_o | output | 1 | High while the decoder watchdog has expired |

## Verification
Several rules hold on every cycle, and the in-RTL properties check them there. Each transition yields a strobe of the matching polarity one cycle after the edge detector sees it. Strobes never collide or repeat. A single received strobe lands on the output. A collision leaves the output unchanged. An expired watchdog always shows the default level. Any strobe clears the fault. Other behaviours show only in the bench's directed scenarios. These are the exact input-to-strobe latency, the refresh period and the level the refresh carries, and the precise cycle at which the watchdog expires once the link is cut. The bench also shows that the fault stays clear across a long idle stretch when refresh keeps the link alive.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

    typedef enum logic [1:0] {
        TX_HOLD    = 2'd0,
        TX_EDGE    = 2'd1,
        TX_REFRESH = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_TRACK = 1'b0,
        RX_FAULT = 1'b1
    } rx_state_e;

endpackage

// File: rtl/iso_sync.sv
module iso_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d_i;
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/iso_tx_encoder.sv
module iso_tx_encoder
    import iso_link_pkg::*;
#(
    parameter int REFRESH_CYCLES = 100,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic set_o,
    output logic clr_o
);
    localparam int CW = (REFRESH_CYCLES > 2) ? $clog2(REFRESH_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(REFRESH_CYCLES - 1);

    logic          lvl_s;
    logic          prev_q;
    logic          lvl_q;
    logic [CW-1:0] cnt_q;
    logic          edge_w;
    tx_state_e     state_q;
    tx_state_e     state_d;

    iso_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (din_i),
        .q_o  (lvl_s)
    );

    assign edge_w = lvl_s ^ prev_q;

    // next-state selection: edge has priority over refresh
    always_comb begin
        if (edge_w)                 state_d = TX_EDGE;
        else if (cnt_q == CNT_LAST) state_d = TX_REFRESH;
        else                        state_d = TX_HOLD;
    end

    // state register with level and idle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_HOLD;
            prev_q  <= 1'b0;
            lvl_q   <= 1'b0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= lvl_s;
            lvl_q   <= lvl_s;
            if (state_d != TX_HOLD) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs decoded from the state register
    always_comb begin
        set_o = 1'b0;
        clr_o = 1'b0;
        unique case (state_q)
            TX_HOLD: begin
                set_o = 1'b0;
                clr_o = 1'b0;
            end
            TX_EDGE, TX_REFRESH: begin
                set_o = lvl_q;
                clr_o = !lvl_q;
            end
            default: begin
                set_o = 1'b0;
                clr_o = 1'b0;
            end
        endcase
    end

    // R3
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_o && clr_o));
    // R3
    single_cycle_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_o |=> !set_o);
    // R1
    rise_to_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_s && !prev_q) |=> set_o);
    // R2
    fall_to_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl_s && prev_q) |=> clr_o);
    // R4
    refresh_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_LAST) |=> (set_o || clr_o));
endmodule

// File: rtl/iso_rx_decoder.sv
module iso_rx_decoder
    import iso_link_pkg::*;
#(
    parameter int   WDOG_CYCLES = 500,
    parameter logic DEFAULT_OUT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic dout_o,
    output logic fault_o
);
    localparam int WW = (WDOG_CYCLES > 2) ? $clog2(WDOG_CYCLES) : 1;
    localparam logic [WW-1:0] WD_LAST = WW'(WDOG_CYCLES - 1);

    rx_state_e     state_q;
    rx_state_e     state_d;
    logic          dout_q;
    logic          dout_d;
    logic [WW-1:0] wd_q;
    logic          any_w;
    logic          expire_w;

    assign any_w    = set_i | clr_i;
    assign expire_w = !any_w && (wd_q == WD_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_TRACK: if (expire_w) state_d = RX_FAULT;
            RX_FAULT: if (any_w)    state_d = RX_TRACK;
            default:  state_d = RX_TRACK;
        endcase
    end

    always_comb begin
        if (set_i && !clr_i)                           dout_d = 1'b1;
        else if (clr_i && !set_i)                      dout_d = 1'b0;
        else if (state_q == RX_TRACK && state_d == RX_FAULT) dout_d = DEFAULT_OUT;
        else                                           dout_d = dout_q;
    end

    // state register with output level and watchdog count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_TRACK;
            dout_q  <= DEFAULT_OUT;
            wd_q    <= '0;
        end else begin
            state_q <= state_d;
            dout_q  <= dout_d;
            if (any_w)                wd_q <= '0;
            else if (wd_q != WD_LAST) wd_q <= wd_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        dout_o  = dout_q;
        fault_o = (state_q == RX_FAULT);
    end

    // R5
    set_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_i) |=> dout_o);
    // R5
    clr_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !dout_o);
    // R6
    collision_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && clr_i) |=> $stable(dout_o));
    // R7
    fault_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (dout_o == DEFAULT_OUT));
    // R8
    strobe_clears_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_w |=> !fault_o);
endmodule

// File: rtl/iso_pulse_link.sv
module iso_pulse_link #(
    parameter int   REFRESH_CYCLES = 100,
    parameter int   WDOG_CYCLES    = 500,
    parameter logic DEFAULT_OUT    = 1'b0,
    parameter int   SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    output logic tx_set_o,
    output logic tx_clr_o,
    input  logic rx_set_i,
    input  logic rx_clr_i,
    output logic data_out,
    output logic fault_o
);
    initial begin
        if (WDOG_CYCLES <= REFRESH_CYCLES || REFRESH_CYCLES < 2 || SYNC_STAGES < 2)
            $error("iso_pulse_link: parameters out of range");
    end

    iso_tx_encoder #(
        .REFRESH_CYCLES(REFRESH_CYCLES),
        .SYNC_STAGES   (SYNC_STAGES)
    ) u_tx (
        .clk  (clk),
        .rst_n(rst_n),
        .din_i(data_in),
        .set_o(tx_set_o),
        .clr_o(tx_clr_o)
    );

    iso_rx_decoder #(
        .WDOG_CYCLES(WDOG_CYCLES),
        .DEFAULT_OUT(DEFAULT_OUT)
    ) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (rx_set_i),
        .clr_i  (rx_clr_i),
        .dout_o (data_out),
        .fault_o(fault_o)
    );
endmodule

// File: tb/iso_pulse_link_tb.sv
module iso_pulse_link_tb;
    localparam int   CLK_PERIOD = 10;
    localparam int   REF_C      = 8;
    localparam int   WD_C       = 20;
    localparam logic DEF_OUT    = 1'b0;
    localparam int   WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_in = 1'b0;
    logic cut = 1'b0;
    logic inj_set = 1'b0;
    logic inj_clr = 1'b0;
    logic tx_set_o, tx_clr_o, data_out, fault_o;
    logic rx_set_i, rx_clr_i;
    int   n_checks = 0;
    int   n_fail = 0;
    int   cyc = 0;

    assign rx_set_i = cut ? inj_set : tx_set_o;
    assign rx_clr_i = cut ? inj_clr : tx_clr_o;

    iso_pulse_link #(
        .REFRESH_CYCLES(REF_C),
        .WDOG_CYCLES   (WD_C),
        .DEFAULT_OUT   (DEF_OUT),
        .SYNC_STAGES   (2)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_in (data_in),
        .tx_set_o(tx_set_o),
        .tx_clr_o(tx_clr_o),
        .rx_set_i(rx_set_i),
        .rx_clr_i(rx_clr_i),
        .data_out(data_out),
        .fault_o (fault_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input int act, input int exp, input string req, input string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
            finish_run();
        end
    end

    // wait at negedges until a transmit strobe is visible
    task automatic wait_strobe();
        for (int i = 0; i < 4 * REF_C; i++) begin
            @(negedge clk);
            if (tx_set_o || tx_clr_o) return;
        end
        check(0, 1, "R4", "no strobe seen while waiting");
    endtask

    // count cycles from a visible strobe to the next one
    task automatic measure_gap(output int gap);
        gap = 0;
        for (int i = 1; i <= 4 * REF_C; i++) begin
            @(negedge clk);
            if (tx_set_o || tx_clr_o) begin
                gap = i;
                return;
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(int'(data_out), int'(DEF_OUT), "R9", "data_out in reset");
        check(int'(fault_o), 0, "R9", "fault in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(int'(tx_set_o || tx_clr_o), 0, "R9", "strobe right after reset");
        check(int'(data_out), int'(DEF_OUT), "R9", "data_out after reset");
    endtask

    task automatic t_transition(input logic lvl);
        string rq;
        int gap;
        rq = lvl ? "R1" : "R2";
        wait_strobe();
        data_in = lvl;
        @(negedge clk);
        check(int'(tx_set_o || tx_clr_o), 0, rq, "early strobe (1)");
        @(negedge clk);
        check(int'(tx_set_o || tx_clr_o), 0, rq, "early strobe (2)");
        @(negedge clk);
        check(int'(tx_set_o), int'(lvl), rq, "set strobe at latency");
        check(int'(tx_clr_o), int'(!lvl), rq, "clr strobe at latency");
        @(negedge clk);
        check(int'(data_out), int'(lvl), "R5", "decoded level");
        check(int'(tx_set_o || tx_clr_o), 0, "R3", "strobe lasts one cycle");
        // edge strobe restarts refresh interval
        measure_gap(gap);
        check(gap, REF_C - 1, "R4", "refresh after edge strobe");
    endtask

    task automatic t_refresh(input logic lvl);
        int gap;
        for (int k = 0; k < 3; k++) begin
            measure_gap(gap);
            check(gap, REF_C, "R4", "refresh period");
            check(int'(tx_set_o), int'(lvl), "R4", "refresh set level");
            check(int'(tx_clr_o), int'(!lvl), "R4", "refresh clr level");
            check(int'(!(tx_set_o && tx_clr_o)), 1, "R3", "no dual strobe");
        end
        check(int'(fault_o), 0, "R7", "no fault while refreshed");
        check(int'(data_out), int'(lvl), "R5", "level held over idle");
    endtask

    task automatic t_watchdog();
        wait_strobe();
        @(negedge clk);
        cut = 1'b1;
        for (int i = 1; i <= WD_C; i++) begin
            @(negedge clk);
            if (i == WD_C - 1) check(int'(fault_o), 0, "R7", "fault before timeout");
            if (i == WD_C - 1) check(int'(data_out), 1, "R5", "level held before timeout");
        end
        check(int'(fault_o), 1, "R7", "fault at timeout");
        check(int'(data_out), int'(DEF_OUT), "R7", "default on fault");
        repeat (5) @(negedge clk);
        check(int'(fault_o), 1, "R7", "fault persists");
    endtask

    task automatic inject(input logic s, input logic c);
        inj_set = s;
        inj_clr = c;
        @(negedge clk);
        inj_set = 1'b0;
        inj_clr = 1'b0;
    endtask

    task automatic t_recovery_and_collision();
        inject(1'b1, 1'b0);
        check(int'(fault_o), 0, "R8", "set clears fault");
        check(int'(data_out), 1, "R8", "set applied on recovery");
        inject(1'b1, 1'b1);
        check(int'(data_out), 1, "R6", "collision holds high");
        inject(1'b0, 1'b1);
        check(int'(data_out), 0, "R5", "clr applied");
        inject(1'b1, 1'b1);
        check(int'(data_out), 0, "R6", "collision holds low");
        // let it fault again, then a collision alone clears it
        repeat (WD_C + 2) @(negedge clk);
        check(int'(fault_o), 1, "R7", "fault again");
        inject(1'b1, 1'b1);
        check(int'(fault_o), 0, "R8", "collision clears fault");
        check(int'(data_out), int'(DEF_OUT), "R6", "collision keeps default");
        cut = 1'b0;
    endtask

    initial begin
        t_reset();
        t_transition(1'b1);
        t_refresh(1'b1);
        t_transition(1'b0);
        t_refresh(1'b0);
        t_transition(1'b1);
        t_watchdog();
        t_recovery_and_collision();
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule